// File: doc/BRIEF.md
# Packed SIMD Saturating Add/Subtract Unit

This unit takes two 32-bit operand words and a 3-bit operation code. It treats each word either as two signed 16-bit halfword lanes or as four signed 8-bit byte lanes. It adds or subtracts the lanes in parallel. On signed overflow, each lane clamps to its most positive or most negative value instead of wrapping.

Besides plain per-lane add and subtract, two exchange forms pair each halfword of the first operand with the opposite halfword of the second operand. In these forms one lane adds and the other subtracts. Codes that name no operation are flagged as illegal and produce a zero result.

Both the operand side and the result side are valid/ready streams, with a single output register between them:
- An operation is accepted on a rising edge when `in_valid` and `in_ready` are both high.
- Its result is presented from the next cycle onward.
- While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` stays low. Back-pressure therefore reaches the producer in the same cycle.
- When the consumer takes a result, the unit can accept a new operation on that same edge, so throughput is one operation per cycle.

Top module: `psat_alu`

## Requirements
- R1: Code 0 (halfword add): out_data[15:0] is the saturated sum of in_a[15:0] and in_b[15:0], and out_data[31:16] is the saturated sum of in_a[31:16] and in_b[31:16].
- R2: Code 3 (halfword subtract): each halfword lane of the result is the saturated difference of the in_a halfword minus the in_b halfword in the same position.
- R3: Code 1 (exchange, subtract low / add high): out_data[15:0] = sat(in_a[15:0] - in_b[31:16]) and out_data[31:16] = sat(in_a[31:16] + in_b[15:0]).
- R4: Code 2 (exchange, add low / subtract high): out_data[15:0] = sat(in_a[15:0] + in_b[31:16]) and out_data[31:16] = sat(in_a[31:16] - in_b[15:0]).
- R5: Code 4 is a byte add and code 7 is a byte subtract. Each of the four bytes is computed from the in_a and in_b bytes at the same bit position and is written back to that position. No carry crosses a byte boundary.
- R6: Overflow clamps each lane independently, and the clamp direction follows the sign of the lane's first operand:
  - A 16-bit lane clamps to 0x8000 when that operand is negative and to 0x7FFF otherwise.
  - An 8-bit lane clamps to 0x80 or 0x7F under the same rule.
  - A lane without overflow holds its wrapped two's-complement result.
- R7: For codes 5 and 6, out_illegal is 1 and out_data is zero. For the six defined codes, out_illegal is 0.
- R8: An operation accepted on a rising edge presents out_valid high with its result after that edge. If no operation is accepted on an edge where the result is taken, or where out_valid is low, out_valid is low after that edge.
- R9: While out_valid is high and out_ready is low, in_ready is low, no new operation is accepted, and out_data and out_illegal stay unchanged.
- R10: A synchronous active-high reset clears out_valid, after which in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are presented |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_a | input | 32 | First operand, packed lanes |
| in_b | input | 32 | Second operand, packed lanes |
| in_op | input | 3 | Operation code (0,1,2,3,4,7 defined; 5,6 illegal) |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Packed saturated result |
| out_illegal | output | 1 | Result came from an undefined code |

## Verification
The properties assume that the producer and consumer follow the handshake:
- `in_valid`, `in_op` and `out_ready` are known at every rising edge once reset is released.
- Reset is held for at least one edge before traffic starts.

The stimulus meets these assumptions by changing every input only on the falling edge, and by keeping all handshake inputs at defined levels from time zero. Under these assumptions, the hold-under-stall and accept-to-valid properties rely only on the port sequence.

The lane arithmetic is checked against a reference model in the bench that uses wide signed integers and explicit clamping. This model is independent of the overflow-by-sign-bit rule used in the RTL.

// File: rtl/psat_pkg.sv
package psat_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned BYTE_W  = WORD_W / 4;
  localparam int unsigned N_HALF  = WORD_W / HALF_W;
  localparam int unsigned N_BYTE  = WORD_W / BYTE_W;
  localparam int unsigned OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HADD   = 3'd0,
    OP_XSUBAD = 3'd1,
    OP_XADDSB = 3'd2,
    OP_HSUB   = 3'd3,
    OP_BADD   = 3'd4,
    OP_RSV5   = 3'd5,
    OP_RSV6   = 3'd6,
    OP_BSUB   = 3'd7
  } op_code_e;

  typedef struct packed {
    logic byte_mode;
    logic xchg;
    logic sub_lo;
    logic sub_hi;
    logic illegal;
  } op_ctrl_t;

endpackage

// File: rtl/psat_lane.sv
module psat_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] r
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] wrapped;
  logic         sign_mix;
  logic         sign_flip;
  logic         ovf;

  always_comb begin
    wrapped   = sub ? (x - y) : (x + y);
    sign_mix  = x[W-1] ^ y[W-1];
    sign_flip = wrapped[W-1] ^ x[W-1];
    ovf       = sign_flip & (sub ? sign_mix : ~sign_mix);
    if (ovf) r = x[W-1] ? MAX_NEG : MAX_POS;
    else     r = wrapped;
  end
endmodule

// File: rtl/psat_decode.sv
module psat_decode
  import psat_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output op_ctrl_t        ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (op_code_e'(op))
      OP_HADD:   ctrl = '{byte_mode:1'b0, xchg:1'b0, sub_lo:1'b0, sub_hi:1'b0, illegal:1'b0};
      OP_XSUBAD: ctrl = '{byte_mode:1'b0, xchg:1'b1, sub_lo:1'b1, sub_hi:1'b0, illegal:1'b0};
      OP_XADDSB: ctrl = '{byte_mode:1'b0, xchg:1'b1, sub_lo:1'b0, sub_hi:1'b1, illegal:1'b0};
      OP_HSUB:   ctrl = '{byte_mode:1'b0, xchg:1'b0, sub_lo:1'b1, sub_hi:1'b1, illegal:1'b0};
      OP_BADD:   ctrl = '{byte_mode:1'b1, xchg:1'b0, sub_lo:1'b0, sub_hi:1'b0, illegal:1'b0};
      OP_BSUB:   ctrl = '{byte_mode:1'b1, xchg:1'b0, sub_lo:1'b1, sub_hi:1'b1, illegal:1'b0};
      default:   ctrl = '{byte_mode:1'b0, xchg:1'b0, sub_lo:1'b0, sub_hi:1'b0, illegal:1'b1};
    endcase
  end
endmodule

// File: rtl/psat_half_unit.sv
module psat_half_unit
  import psat_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              xchg,
  input  logic              sub_lo,
  input  logic              sub_hi,
  output logic [WORD_W-1:0] r
);
  for (genvar i = 0; i < N_HALF; i++) begin : g_half
    localparam int unsigned OPP = N_HALF - 1 - i;
    logic [HALF_W-1:0] y_sel;
    logic              sub_sel;
    assign y_sel   = xchg ? b[OPP*HALF_W +: HALF_W] : b[i*HALF_W +: HALF_W];
    assign sub_sel = (i == 0) ? sub_lo : sub_hi;
    psat_lane #(.W(HALF_W)) u_lane (
      .x  (a[i*HALF_W +: HALF_W]),
      .y  (y_sel),
      .sub(sub_sel),
      .r  (r[i*HALF_W +: HALF_W])
    );
  end
endmodule

// File: rtl/psat_byte_unit.sv
module psat_byte_unit
  import psat_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              sub,
  output logic [WORD_W-1:0] r
);
  for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
    psat_lane #(.W(BYTE_W)) u_lane (
      .x  (a[i*BYTE_W +: BYTE_W]),
      .y  (b[i*BYTE_W +: BYTE_W]),
      .sub(sub),
      .r  (r[i*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/psat_alu.sv
module psat_alu
  import psat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [OP_W-1:0]   in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_illegal
);
  op_ctrl_t          ctrl;
  logic [WORD_W-1:0] half_res;
  logic [WORD_W-1:0] byte_res;
  logic [WORD_W-1:0] next_res;
  logic              accept;

  psat_decode u_dec (.op(in_op), .ctrl(ctrl));

  psat_half_unit u_half (
    .a     (in_a),
    .b     (in_b),
    .xchg  (ctrl.xchg),
    .sub_lo(ctrl.sub_lo),
    .sub_hi(ctrl.sub_hi),
    .r     (half_res)
  );

  psat_byte_unit u_byte (
    .a  (in_a),
    .b  (in_b),
    .sub(ctrl.sub_lo),
    .r  (byte_res)
  );

  always_comb begin
    if (ctrl.illegal)        next_res = '0;
    else if (ctrl.byte_mode) next_res = byte_res;
    else                     next_res = half_res;
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_data    <= next_res;
      out_illegal <= ctrl.illegal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/psat_alu_chk.sv
module psat_alu_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [2:0]  in_op,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_illegal
);
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R8

  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && (!out_valid || out_ready)) |=> !out_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal))); // R9

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_op == 3'd5 || in_op == 3'd6)) |=> out_illegal); // R7

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_data == 32'd0)); // R7
endmodule

bind psat_alu psat_alu_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_illegal(out_illegal)
);

// File: tb/psat_alu_bench.sv
module psat_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [2:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_illegal;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psat_alu u_psat_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_illegal(out_illegal)
  );

  function automatic int clampv(input int v, input int w);
    int lim;
    lim = 1 << (w - 1);
    if (v > lim - 1) return lim - 1;
    if (v < -lim)    return -lim;
    return v;
  endfunction

  function automatic logic [15:0] h16(input logic [15:0] x, input logic [15:0] y, input bit s);
    int v;
    logic [31:0] t;
    v = s ? (int'($signed(x)) - int'($signed(y))) : (int'($signed(x)) + int'($signed(y)));
    t = clampv(v, 16);
    return t[15:0];
  endfunction

  function automatic logic [7:0] b8(input logic [7:0] x, input logic [7:0] y, input bit s);
    int v;
    logic [31:0] t;
    v = s ? (int'($signed(x)) - int'($signed(y))) : (int'($signed(x)) + int'($signed(y)));
    t = clampv(v, 8);
    return t[7:0];
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    logic [31:0] r;
    r = '0;
    case (op)
      3'd0: r = {h16(a[31:16], b[31:16], 0), h16(a[15:0], b[15:0], 0)};
      3'd1: r = {h16(a[31:16], b[15:0], 0),  h16(a[15:0], b[31:16], 1)};
      3'd2: r = {h16(a[31:16], b[15:0], 1),  h16(a[15:0], b[31:16], 0)};
      3'd3: r = {h16(a[31:16], b[31:16], 1), h16(a[15:0], b[15:0], 1)};
      3'd4, 3'd7: for (int k = 0; k < 4; k++) r[k*8 +: 8] = b8(a[k*8 +: 8], b[k*8 +: 8], op == 3'd7);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive one operation at a falling edge, check result one edge later
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic [2:0] op, input logic [31:0] exp);
    in_a = a; in_b = b; in_op = op; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_data, exp);
    check({req, " flag"}, {31'd0, out_illegal}, {31'd0, (op == 3'd5 || op == 3'd6)});
  endtask

  task automatic t_reset;
    check("R10 reset valid", {31'd0, out_valid}, 32'd0);
    check("R10 reset ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_half_add;
    run_op("R1 plain", 32'h0012_0034, 32'h0001_0002, 3'd0, 32'h0013_0036);
    run_op("R6 R1 hi ovf", 32'h7FFF_0001, 32'h0001_0001, 3'd0, 32'h7FFF_0002);
    run_op("R6 R1 lo ovf neg", 32'h0001_8000, 32'h0001_FFFF, 3'd0, 32'h0002_8000);
    run_op("R6 R1 no ovf mixed", 32'h8000_7FFF, 32'h7FFF_8000, 3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_half_sub;
    run_op("R2 plain", 32'h0010_0020, 32'h0003_0005, 3'd3, 32'h000D_001B);
    run_op("R6 R2 hi ovf", 32'h8000_0005, 32'h0001_0003, 3'd3, 32'h8000_0002);
    run_op("R6 R2 lo ovf", 32'h0000_7FFF, 32'h0000_FFFF, 3'd3, 32'h0000_7FFF);
  endtask

  task automatic t_exchange;
    run_op("R3 plain", 32'h0010_0020, 32'h0003_0005, 3'd1, 32'h0015_001D);
    run_op("R4 plain", 32'h0010_0020, 32'h0003_0005, 3'd2, 32'h000B_0023);
    run_op("R6 R3 both ovf", 32'h7FFF_8000, 32'h0001_0001, 3'd1, 32'h7FFF_8000);
    run_op("R6 R4 both ovf", 32'h8000_7FFF, 32'h0001_0001, 3'd2, 32'h8000_7FFF);
  endtask

  task automatic t_bytes;
    run_op("R5 R6 byte add", 32'h7F01_8010, 32'h0101_FFF0, 3'd4, 32'h7F02_8000);
    run_op("R5 R6 byte sub", 32'h8005_7F00, 32'h0102_FF01, 3'd7, 32'h8003_7FFF);
    run_op("R5 no carry", 32'h00FF_00FF, 32'h0001_0001, 3'd4, 32'h0000_0000);
  endtask

  task automatic t_illegal;
    run_op("R7 code5", 32'h1234_5678, 32'h1111_2222, 3'd5, 32'h0);
    run_op("R7 code6", 32'h7FFF_7FFF, 32'h7FFF_7FFF, 3'd6, 32'h0);
    run_op("R7 defined after", 32'h0001_0001, 32'h0001_0001, 3'd0, 32'h0002_0002);
  endtask

  task automatic t_random;
    logic [2:0] codes [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7};
    logic [31:0] edges [4] = '{32'h7FFF_7F7F, 32'h8000_8080, 32'hFFFF_FFFF, 32'h0000_0001};
    for (int i = 0; i < 120; i++) begin
      logic [31:0] a, b;
      logic [2:0]  op;
      a  = (i % 5 == 0) ? edges[$urandom % 4] : $urandom;
      b  = (i % 7 == 0) ? edges[$urandom % 4] : $urandom;
      op = codes[i % 6];
      run_op("R1 R2 R3 R4 R5 random", a, b, op, model(a, b, op));
    end
  endtask

  task automatic t_latency;
    in_a = 32'h0001_0001; in_b = 32'h0001_0001; in_op = 3'd0; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 valid next cycle", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R8 valid drops", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_backpressure;
    out_ready = 1'b0;
    in_a = 32'h0010_0020; in_b = 32'h0003_0005; in_op = 3'd3; in_valid = 1'b1;
    @(negedge clk);
    in_a = 32'h0100_0200; in_b = 32'h0001_0001; in_op = 3'd0;
    for (int k = 0; k < 3; k++) begin
      check("R9 ready low", {31'd0, in_ready}, 32'd0);
      check("R9 held data", out_data, 32'h000D_001B);
      check("R9 held valid", {31'd0, out_valid}, 32'd1);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next after release", out_data, 32'h0101_0201);
    check("R9 next valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R8 drain", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_mid_reset;
    out_ready = 1'b0;
    in_a = 32'h1; in_b = 32'h1; in_op = 3'd0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset clears", {31'd0, out_valid}, 32'd0);
    check("R10 ready after", {31'd0, in_ready}, 32'd1);
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_half_add();
    t_half_sub();
    t_exchange();
    t_bytes();
    t_illegal();
    t_random();
    t_latency();
    t_backpressure();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule